// File: doc/BRIEF.md
# Three-Axis Windowed Rate Interrupt with Debounce

This block watches a stream of signed 16-bit angular-rate samples on three axes and raises interrupts when the samples stay inside chosen magnitude windows. A threshold splits each axis into four ranges: strongly positive, weakly positive, weakly negative and strongly negative. A per-axis set of range enables picks which ranges count as that axis's condition. The threshold is either a per-axis byte scaled by 256 or one 16-bit value shared by every axis.

A condition does not assert until the axis has met it on a programmed number of consecutive samples. The debounce length is a per-axis byte, or one shared 16-bit length. The debounced condition bits are always visible and can be frozen. Two interrupt outputs combine them: an AND output that needs every axis selected in its mask, and an OR output that needs any axis selected in its mask.

Top module: `rate_window_irq`

## Requirements
- R1: With threshold TH, an axis sample s falls in exactly one range, whose index is the bit of that axis's 4-bit enable field: bit 0 for s > TH, bit 1 for 0 <= s <= TH, bit 2 for -TH <= s < 0, bit 3 for s < -TH. A sample equal to +TH or -TH is in a low range and zero is in bit 1's range.
- R2: When shared_ref is 0, the threshold of axis a is byte a of ref_lvl multiplied by 256.
- R3: When shared_ref is 1, every axis uses the threshold {ref_lvl[7:0], ref_lvl[15:8]}: the X byte is the high byte and the Y byte the low byte.
- R4: The axis match is true when the sample lies in any range whose enable bit is 1. An axis whose four enable bits are all 0 never asserts its condition.
- R5: cond_live[a] becomes 1 on the sample at which axis a has matched on D consecutive samples, D being its debounce length, and stays 1 while it keeps matching. Lengths 0 and 1 both assert on the first matching sample.
- R6: A sample that does not match clears that axis's consecutive count and clears cond_live[a] on that sample (unless frozen).
- R7: When shared_deb is 1, every axis uses the 16-bit debounce length {deb_lvl[7:0], deb_lvl[15:8]} (X byte high, Y byte low); otherwise axis a uses byte a of deb_lvl.
- R8: int_and is 1 when and_mask is nonzero and every axis with its and_mask bit set has cond_live at 1; it is 0 for an empty mask.
- R9: int_or is 1 when at least one axis with its or_mask bit set has cond_live at 1.
- R10: cond_live does not depend on the masks. While freeze is 1, cond_live holds its value across samples, and the consecutive counts keep running.
- R11: Only a cycle with smp_valid at 1 changes the counts or cond_live; samples offered with smp_valid at 0 have no effect.
- R12: After reset, cond_live, int_and and int_or are 0 and all counts are 0. Each new sample is reflected in cond_live one clock after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample set is present on smp_data |
| smp_data | input | 48 | Signed samples; axis a in bits [16a+15:16a] (X, Y, Z) |
| ref_lvl | input | 24 | Threshold bytes; axis a in bits [8a+7:8a] |
| shared_ref | input | 1 | Use one 16-bit threshold built from the X and Y bytes |
| deb_lvl | input | 24 | Debounce bytes; axis a in bits [8a+7:8a] |
| shared_deb | input | 1 | Use one 16-bit debounce length built from the X and Y bytes |
| range_en | input | 12 | Range enables; axis a in bits [4a+3:4a] |
| and_mask | input | 3 | Axes required by int_and |
| or_mask | input | 3 | Axes considered by int_or |
| freeze | input | 1 | Hold cond_live |
| cond_live | output | 3 | Debounced per-axis conditions |
| int_and | output | 1 | All masked axes hold their condition |
| int_or | output | 1 | Any masked axis holds its condition |

## Verification
The bench drives samples exactly on +TH, -TH, TH+1 and zero, where a design with a strict-versus-inclusive comparison slip would put the sample in the wrong range and flip the condition. It runs a debounce of three with a break in the middle, which a design that only decremented or paused its count would report too early, and a shared length of 258 that exceeds one byte, which a design that kept only the low byte would trip after two samples. Empty masks, freeze held across non-matching samples and samples offered without the valid strobe target designs that raise int_and on nothing, let frozen bits drop, or count idle cycles. A long randomized stretch then compares against the behavioural model on every clock.

// File: rtl/rwi_pkg.sv
package rwi_pkg;
   // Range index doubles as the bit position in each axis's enable field.
   typedef enum logic [1:0] {
      RNG_HIGH_POS = 2'd0,
      RNG_LOW_POS  = 2'd1,
      RNG_LOW_NEG  = 2'd2,
      RNG_HIGH_NEG = 2'd3
   } rng_e;

   localparam int RNG_COUNT = 4;
endpackage

// File: rtl/rwi_classify.sv
module rwi_classify
   import rwi_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic signed [DATA_W-1:0] sample,
   input  logic        [DATA_W-1:0] thresh,
   output rng_e                     rng
);
   localparam int EXT_W = DATA_W + 2;

   logic signed [EXT_W-1:0] s_ext;
   logic signed [EXT_W-1:0] th_pos;
   logic signed [EXT_W-1:0] th_neg;

   assign s_ext  = EXT_W'(sample);
   assign th_pos = $signed({2'b00, thresh});
   assign th_neg = -th_pos;

   // Boundary values land in the low ranges.
   always_comb begin
      if (s_ext > th_pos)
         rng = RNG_HIGH_POS;
      else if (s_ext >= 0)
         rng = RNG_LOW_POS;
      else if (s_ext >= th_neg)
         rng = RNG_LOW_NEG;
      else
         rng = RNG_HIGH_NEG;
   end
endmodule

// File: rtl/rwi_debounce.sv
module rwi_debounce #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic             match,
   input  logic             freeze,
   input  logic [CNT_W-1:0] deb_len,
   output logic             cond
);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, cnt_nxt, deb_eff;
   logic             cond_nxt;

   assign deb_eff = (deb_len == '0) ? CNT_ONE : deb_len;

   always_comb begin
      if (!match)
         cnt_nxt = '0;
      else if (cnt_q == CNT_MAX)
         cnt_nxt = cnt_q;
      else
         cnt_nxt = cnt_q + CNT_ONE;
      cond_nxt = match && (cnt_nxt >= deb_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cond  <= 1'b0;
      end else if (smp_valid) begin
         cnt_q <= cnt_nxt;
         if (!freeze)
            cond <= cond_nxt;
      end
   end

   // R6
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !match) |=> (cnt_q == '0));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(cond) && $stable(cnt_q)));

   // R10
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(cond));

   // R5
   deb_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cond) |-> (cnt_q >= $past(deb_eff)));
endmodule

// File: rtl/rwi_combine.sv
module rwi_combine #(
   parameter int NAXES = 3
) (
   input  logic [NAXES-1:0] cond,
   input  logic [NAXES-1:0] and_mask,
   input  logic [NAXES-1:0] or_mask,
   output logic             int_and,
   output logic             int_or
);
   logic [NAXES-1:0] and_ok;
   logic [NAXES-1:0] or_hit;

   genvar a;
   generate
      for (a = 0; a < NAXES; a++) begin : g_ax
         assign and_ok[a] = cond[a] | ~and_mask[a];
         assign or_hit[a] = cond[a] &  or_mask[a];
      end
   endgenerate

   assign int_and = (|and_mask) & (&and_ok);
   assign int_or  = |or_hit;
endmodule

// File: rtl/rate_window_irq.sv
module rate_window_irq
   import rwi_pkg::*;
#(
   parameter int NAXES  = 3,
   parameter int DATA_W = 16,
   parameter int REF_W  = 8,
   parameter int DEB_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_valid,
   input  logic [NAXES*DATA_W-1:0] smp_data,
   input  logic [NAXES*REF_W-1:0]  ref_lvl,
   input  logic                    shared_ref,
   input  logic [NAXES*DEB_W-1:0]  deb_lvl,
   input  logic                    shared_deb,
   input  logic [NAXES*4-1:0]      range_en,
   input  logic [NAXES-1:0]        and_mask,
   input  logic [NAXES-1:0]        or_mask,
   input  logic                    freeze,
   output logic [NAXES-1:0]        cond_live,
   output logic                    int_and,
   output logic                    int_or
);
   localparam int CNT_W  = 2 * DEB_W;
   localparam int LOW_W  = DATA_W - REF_W;

   generate
      if (NAXES < 2) begin : g_bad_axes
         $error("rate_window_irq: shared modes need at least two axes");
      end
      if (DATA_W != 2 * REF_W) begin : g_bad_ref
         $error("rate_window_irq: DATA_W must be twice REF_W");
      end
      if (RNG_COUNT != 4) begin : g_bad_rng
         $error("rate_window_irq: range enable field must be 4 bits");
      end
   endgenerate

   // Shared values: X byte high, Y byte low.
   logic [DATA_W-1:0] th_shared;
   logic [CNT_W-1:0]  deb_shared;

   assign th_shared  = {ref_lvl[0 +: REF_W], ref_lvl[REF_W +: REF_W]};
   assign deb_shared = {deb_lvl[0 +: DEB_W], deb_lvl[DEB_W +: DEB_W]};

   logic [NAXES-1:0] match;

   genvar a;
   generate
      for (a = 0; a < NAXES; a++) begin : g_axis
         logic [DATA_W-1:0]        th_axis;
         logic [CNT_W-1:0]         deb_axis;
         logic signed [DATA_W-1:0] smp_axis;
         logic [3:0]               en_axis;
         rng_e                     rng;

         assign th_axis  = shared_ref ? th_shared
                         : {ref_lvl[a*REF_W +: REF_W], {LOW_W{1'b0}}};
         assign deb_axis = shared_deb ? deb_shared
                         : {{DEB_W{1'b0}}, deb_lvl[a*DEB_W +: DEB_W]};
         assign smp_axis = $signed(smp_data[a*DATA_W +: DATA_W]);
         assign en_axis  = range_en[a*4 +: 4];

         rwi_classify #(.DATA_W(DATA_W)) u_cls (
            .sample (smp_axis),
            .thresh (th_axis),
            .rng    (rng)
         );

         assign match[a] = en_axis[rng];

         rwi_debounce #(.CNT_W(CNT_W)) u_deb (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .match     (match[a]),
            .freeze    (freeze),
            .deb_len   (deb_axis),
            .cond      (cond_live[a])
         );

         // R4
         no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && !freeze && en_axis == 4'b0000) |=> !cond_live[a]);
      end
   endgenerate

   rwi_combine #(.NAXES(NAXES)) u_comb (
      .cond     (cond_live),
      .and_mask (and_mask),
      .or_mask  (or_mask),
      .int_and  (int_and),
      .int_or   (int_or)
   );

   // R9
   and_implies_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_and && ((and_mask & or_mask) != '0)) |-> int_or);

   // R8
   empty_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (and_mask == '0) |-> !int_and);
endmodule

// File: tb/rate_window_irq_test.sv
module rate_window_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [47:0] smp_data = '0;
   logic [23:0] ref_lvl = '0;
   logic        shared_ref = 1'b0;
   logic [23:0] deb_lvl = '0;
   logic        shared_deb = 1'b0;
   logic [11:0] range_en = '0;
   logic [2:0]  and_mask = '0;
   logic [2:0]  or_mask = '0;
   logic        freeze = 1'b0;
   logic [2:0]  cond_live;
   logic        int_and, int_or;

   int checks = 0;
   int errors = 0;
   bit started = 0;
   bit done = 0;
   string cur_req = "R12";

   always #4 clk = ~clk;

   rate_window_irq uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .ref_lvl(ref_lvl), .shared_ref(shared_ref), .deb_lvl(deb_lvl),
      .shared_deb(shared_deb), .range_en(range_en), .and_mask(and_mask),
      .or_mask(or_mask), .freeze(freeze), .cond_live(cond_live),
      .int_and(int_and), .int_or(int_or)
   );

   // Behavioural reference model
   int m_cnt [3];
   bit m_cond [3];

   function automatic int range_of(int s, int th);
      if (s > th) return 0;
      if (s >= 0) return 1;
      if (s >= -th) return 2;
      return 3;
   endfunction

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         for (int a = 0; a < 3; a++) begin m_cnt[a] = 0; m_cond[a] = 0; end
      end else if (smp_valid) begin
         for (int a = 0; a < 3; a++) begin
            int th, deb, s, r;
            bit hit;
            th  = shared_ref ? (int'(ref_lvl[7:0]) * 256 + int'(ref_lvl[15:8]))
                             : int'(ref_lvl[a*8 +: 8]) * 256;
            deb = shared_deb ? (int'(deb_lvl[7:0]) * 256 + int'(deb_lvl[15:8]))
                             : int'(deb_lvl[a*8 +: 8]);
            if (deb == 0) deb = 1;
            s   = int'($signed(smp_data[a*16 +: 16]));
            r   = range_of(s, th);
            hit = range_en[a*4 + r];
            if (!hit) m_cnt[a] = 0;
            else if (m_cnt[a] < 65535) m_cnt[a] = m_cnt[a] + 1;
            if (!freeze) m_cond[a] = hit && (m_cnt[a] >= deb);
         end
      end
   end

   function automatic bit [2:0] m_vec();
      return {m_cond[2], m_cond[1], m_cond[0]};
   endfunction

   always @(negedge clk) begin
      if (started && !done) begin
         bit [2:0] ev;
         bit ea, eo;
         ev = m_vec();
         ea = (and_mask != 0) && ((ev & and_mask) == and_mask);
         eo = (ev & or_mask) != 0;
         checks++;
         if (cond_live !== ev || int_and !== ea || int_or !== eo) begin
            errors++;
            $display("FAIL %s: cond/and/or actual %b/%b/%b expected %b/%b/%b at %0t",
                     cur_req, cond_live, int_and, int_or, ev, ea, eo, $time);
         end
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(bit v, int x, int y, int z);
      smp_valid = v;
      smp_data  = {16'(z), 16'(y), 16'(x)};
      @(posedge clk); #2;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R12 reset state
      chk(cond_live == 3'b000 && !int_and && !int_or, "R12", int'(cond_live), 0);
      rst_n = 1'b1;
      put(0, 0, 0, 0);

      // R1 R2: per-axis threshold 0x10*256 = 4096, boundary samples
      cur_req = "R2";
      ref_lvl = {8'h10, 8'h10, 8'h10};
      deb_lvl = '0;
      range_en = {4'b0001, 4'b0100, 4'b0010};
      and_mask = 3'b111; or_mask = 3'b111;
      put(1, 4096, -4096, 4097);
      #2 chk(cond_live == 3'b111, "R1", int'(cond_live), 7);
      cur_req = "R1";
      put(1, 4097, -4097, 4096);
      #2 chk(cond_live == 3'b000, "R1", int'(cond_live), 0);
      range_en = {4'b1000, 4'b0010, 4'b0010};
      put(1, 0, 0, -4097);
      #2 chk(cond_live == 3'b111, "R1", int'(cond_live), 7);

      // R3 shared threshold 0x1234
      cur_req = "R3";
      shared_ref = 1; ref_lvl = {8'h77, 8'h34, 8'h12};
      range_en = {4'b0010, 4'b0010, 4'b0001};
      put(1, 16'h1235, 16'h1234, -1);
      #2 chk(cond_live == 3'b011, "R3", int'(cond_live), 3);
      put(1, 16'h1234, 16'h1235, 5);
      #2 chk(cond_live == 3'b100, "R3", int'(cond_live), 4);
      shared_ref = 0;

      // R4 no enables
      cur_req = "R4";
      range_en = 12'h00F;
      put(1, 100, 100, -30000);
      #2 chk(cond_live == 3'b001, "R4", int'(cond_live), 1);

      // R5 debounce of 3 on X, 1 on Y, 0 on Z
      cur_req = "R5";
      ref_lvl = {8'h01, 8'h01, 8'h01};
      range_en = 12'h111;
      deb_lvl = {8'd0, 8'd1, 8'd3};
      put(0, 0, 0, 0);
      put(1, 0, 0, 0);
      put(1, 2000, 2000, 2000);
      #2 chk(cond_live == 3'b110, "R5", int'(cond_live), 6);
      put(1, 2000, 2000, 2000);
      put(1, 2000, 2000, 2000);
      #2 chk(cond_live == 3'b111, "R5", int'(cond_live), 7);

      // R6 break resets the count
      cur_req = "R6";
      put(1, 0, 2000, 2000);
      #2 chk(cond_live == 3'b110, "R6", int'(cond_live), 6);
      put(1, 2000, 2000, 2000);
      put(1, 2000, 2000, 2000);
      #2 chk(cond_live[0] == 1'b0, "R6", int'(cond_live[0]), 0);
      put(1, 2000, 2000, 2000);
      #2 chk(cond_live[0] == 1'b1, "R6", int'(cond_live[0]), 1);

      // R11 idle cycles with non-matching data
      cur_req = "R11";
      put(0, 0, 0, 0);
      put(0, -5, -5, -5);
      #2 chk(cond_live == 3'b111, "R11", int'(cond_live), 7);

      // R7 shared debounce 0x0102 = 258
      cur_req = "R7";
      put(1, 0, 0, 0);
      shared_deb = 1; deb_lvl = {8'd0, 8'h02, 8'h01};
      for (int i = 0; i < 257; i++) put(1, 2000, 2000, 2000);
      #2 chk(cond_live == 3'b000, "R7", int'(cond_live), 0);
      put(1, 2000, 2000, 2000);
      #2 chk(cond_live == 3'b111, "R7", int'(cond_live), 7);
      shared_deb = 0; deb_lvl = '0;

      // R8 R9 masks
      cur_req = "R8";
      put(1, 2000, 0, 2000);
      and_mask = 3'b000; or_mask = 3'b010;
      #2 chk(!int_and && !int_or, "R8", int'({int_and, int_or}), 0);
      and_mask = 3'b101; or_mask = 3'b000;
      #2 chk(int_and && !int_or, "R8", int'({int_and, int_or}), 2);
      cur_req = "R9";
      and_mask = 3'b011; or_mask = 3'b011;
      #2 chk(!int_and && int_or, "R9", int'({int_and, int_or}), 1);
      @(posedge clk); #2;

      // R10 freeze
      cur_req = "R10";
      and_mask = 3'b000; or_mask = 3'b000;
      #2 chk(cond_live == 3'b101, "R10", int'(cond_live), 5);
      freeze = 1;
      put(1, 0, 2000, 0);
      put(1, 0, 2000, 0);
      #2 chk(cond_live == 3'b101, "R10", int'(cond_live), 5);
      freeze = 0;
      put(1, 0, 2000, 0);
      #2 chk(cond_live == 3'b010, "R10", int'(cond_live), 2);

      // Randomized run
      cur_req = "R5";
      for (int i = 0; i < 4000; i++) begin
         if (i % 200 == 0) begin
            ref_lvl = 24'($urandom);
            deb_lvl = {5'd0, 3'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom)};
            range_en = 12'($urandom);
            shared_ref = 1'($urandom);
            shared_deb = 1'($urandom) & 1'($urandom);
         end
         and_mask = 3'($urandom);
         or_mask  = 3'($urandom);
         freeze   = ($urandom % 16) == 0;
         put(($urandom % 4) != 0,
             int'($signed(16'($urandom))) >>> ($urandom % 4),
             int'($signed(16'($urandom))) >>> ($urandom % 4),
             int'($signed(16'($urandom))) >>> ($urandom % 4));
      end
      put(0, 0, 0, 0);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule